// File: doc/BRIEF.md
# Interleaved Bidirectional Shift-Latch Driver

This block is the logic core of a 64-channel serial-to-parallel output driver. Four serial lanes feed four 16-stage shift registers that share one clock, so every rising edge moves four bits in at once. The lanes are interleaved across the channels: lane k (0-based) owns channels k, k+4, k+8 and so on up to k+60.

A 64-bit holding latch sits between the shift registers and the outputs. Output logic then either drives the held data, drives its inverse, or forces every channel to one level. A direction input picks forward or reverse shifting. It also swaps which of the two lane pin groups receives serial data and which one carries the cascade output to the next device in a chain. Each bidirectional lane pin is modelled as a separate input port and output port. The side that is not in use is driven with 0.

Top module: `lane_shift_latch_driver`

## Requirements
- R1: Each rising edge of `clk` shifts one bit into each of the four lanes. Stage s (0..15) of lane k (0..3) appears on channel bit 4*s+k of `chan_out`.
- R2: With `dir_fwd`=1, `grp_a_in[j]` enters lane j at stage 0, and data moves toward stage 15 (channels 60..63).
- R3: With `dir_fwd`=0, `grp_b_in[j]` enters lane 3-j at stage 15, and data moves toward stage 0.
- R4: The cascade outputs depend on direction. With `dir_fwd`=1, `grp_b_out[j]` shows stage 15 of lane j and `grp_a_out` is 0. With `dir_fwd`=0, `grp_a_out[j]` shows stage 0 of lane 3-j and `grp_b_out` is 0.
- R5: Shifting and the cascade outputs do not depend on `latch_en`, `show` or `pol`.
- R6: While `latch_en`=1 the holding latch is transparent, so `chan_out` follows the current shift contents in the same cycle. While `latch_en`=0 it keeps the value it had when `latch_en` was last high at a clock edge.
- R7: The output code works as follows:
  - `show`=0, `pol`=0 drives every channel to 1.
  - `show`=0, `pol`=1 drives every channel to 0.
  - `show`=1, `pol`=1 drives the held data.
  - `show`=1, `pol`=0 drives the inverse of the held data.
- R8: While `rst_n`=0, every shift stage and every latch bit is 0. As a result, the cascade outputs are 0 and `chan_out` is 0 when `show`=1 and `pol`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge |
| rst_n | input | 1 | Active-low reset of shift stages and latch |
| dir_fwd | input | 1 | 1: forward shift, group A in; 0: reverse shift, group B in |
| grp_a_in | input | 4 | Lane pin group A, input side |
| grp_b_in | input | 4 | Lane pin group B, input side |
| grp_a_out | output | 4 | Lane pin group A, output side (cascade when reverse) |
| grp_b_out | output | 4 | Lane pin group B, output side (cascade when forward) |
| latch_en | input | 1 | 1: latch transparent; 0: hold |
| show | input | 1 | 0: force all channels; 1: pass data |
| pol | input | 1 | Polarity selector, see R7 |
| chan_out | output | 64 | Channel outputs |

## Verification
Shifting and latch transparency can fall in the same cycle.

The bench provokes this by keeping `latch_en` high across a shift edge and then dropping it. The held value must then equal the contents after that edge, not before it, and it is judged against a shift computed in the bench. It also shifts new data with the latch closed, and checks that the cascade pins move while `chan_out` stays frozen.

// File: rtl/lane_shift_latch_driver.sv
module lane_shift_latch_driver #(
  parameter int LANES = 4,
  parameter int DEPTH = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   dir_fwd,
  input  logic [LANES-1:0]       grp_a_in,
  input  logic [LANES-1:0]       grp_b_in,
  output logic [LANES-1:0]       grp_a_out,
  output logic [LANES-1:0]       grp_b_out,
  input  logic                   latch_en,
  input  logic                   show,
  input  logic                   pol,
  output logic [LANES*DEPTH-1:0] chan_out
);
  localparam int CH = LANES * DEPTH;

  logic [LANES-1:0][DEPTH-1:0] sr_q, sr_d;
  logic [LANES-1:0]            lane_in;
  logic [CH-1:0]               cur_flat, nxt_flat, lat_q, held;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_in[k] = dir_fwd ? grp_a_in[k] : grp_b_in[LANES-1-k];
    assign sr_d[k]    = dir_fwd ? {sr_q[k][DEPTH-2:0], lane_in[k]}
                                : {lane_in[k], sr_q[k][DEPTH-1:1]};
    assign grp_b_out[k] = dir_fwd ? sr_q[k][DEPTH-1] : 1'b0;
    assign grp_a_out[k] = dir_fwd ? 1'b0 : sr_q[LANES-1-k][0];
    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      assign cur_flat[s*LANES+k] = sr_q[k][s];
      assign nxt_flat[s*LANES+k] = sr_d[k][s];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      lat_q <= '0;
    end else begin
      sr_q <= sr_d;
      if (latch_en) lat_q <= nxt_flat;
    end
  end

  assign held     = latch_en ? cur_flat : lat_q;
  assign chan_out = show ? (pol ? held : ~held) : {CH{~pol}};

  // R2: forward shift moves stage DEPTH-2 into the cascade stage
  a_r2_fwd_advance: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dir_fwd) && dir_fwd) |-> grp_b_out[0] == $past(sr_q[0][DEPTH-2]));

  // R3: reverse shift moves stage 1 of the mirrored lane to cascade
  a_r3_rev_advance: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!dir_fwd) && !dir_fwd) |-> grp_a_out[0] == $past(sr_q[LANES-1][1]));

  // R4: only one group carries cascade data
  a_r4_idle_group: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_fwd ? grp_a_out : grp_b_out) == '0);

  // R6: closed latch with steady code keeps outputs still
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_en && $past(!latch_en) && $stable(show) && $stable(pol)) |-> $stable(chan_out));

  // R7: blanked outputs are uniform
  a_r7_blank_uniform: assert property (@(posedge clk) disable iff (!rst_n)
    !show |-> ($countones(chan_out) == 0 || $countones(chan_out) == CH));

  // R8: reset leaves cascades clear
  a_r8_reset_clear: assert property (@(posedge clk)
    !rst_n |-> (grp_a_out == '0 && grp_b_out == '0));
endmodule

// File: tb/tb_lane_shift_latch_driver.sv
module tb_lane_shift_latch_driver;
  localparam int CLK_PERIOD = 10;
  localparam int CH = 64;

  logic clk = 0, rst_n = 0, dir_fwd = 1, latch_en = 0, show = 1, pol = 1;
  logic [3:0] grp_a_in = 0, grp_b_in = 0, grp_a_out, grp_b_out;
  logic [CH-1:0] chan_out, e16, e17, hold_val;
  int checks = 0, fails = 0;
  bit done = 0;

  // bits[3]=show bits[2]=pol bits[1:0]=kind: 0 all ones, 1 all zeros, 2 inverted, 3 data
  localparam logic [3:0] VEC [4] = '{4'b0000, 4'b0101, 4'b1010, 4'b1111};

  lane_shift_latch_driver dut (.clk(clk), .rst_n(rst_n), .dir_fwd(dir_fwd),
    .grp_a_in(grp_a_in), .grp_b_in(grp_b_in), .grp_a_out(grp_a_out),
    .grp_b_out(grp_b_out), .latch_en(latch_en), .show(show), .pol(pol),
    .chan_out(chan_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [CH-1:0] act, logic [CH-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [3:0] pf(int i); return 4'(i*5+3); endfunction
  function automatic logic [3:0] pr(int i); return 4'(i*7+1); endfunction
  function automatic logic [3:0] rev4(logic [3:0] v); return {v[0], v[1], v[2], v[3]}; endfunction

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) tick();
    chk("R8 chan", chan_out, '0);
    chk("R8 a_out", 64'(grp_a_out), '0);
    chk("R8 b_out", 64'(grp_b_out), '0);
    rst_n = 1;

    // forward load; R5: latch_en/show/pol do not disturb shifting
    dir_fwd = 1; grp_b_in = 4'hF;
    for (int i = 0; i < 16; i++) begin grp_a_in = pf(i); tick(); end
    for (int i = 0; i < 16; i++) e16[4*(15-i) +: 4] = pf(i);
    e17 = {e16[CH-5:0], pf(16)};
    chk("R6 closed latch during R2 load", chan_out, '0);
    chk("R4 fwd cascade", 64'(grp_b_out), 64'(pf(0)));
    chk("R4 fwd idle group", 64'(grp_a_out), '0);
    latch_en = 1; #1;
    chk("R6 transparent R1 R2 map", chan_out, e16);
    grp_a_in = pf(16); tick();
    chk("R6 transparent after shift", chan_out, e17);
    latch_en = 0; #1;
    chk("R6 shift and latch same cycle", chan_out, e17);
    grp_a_in = pf(17); tick();
    chk("R6 hold while shifting", chan_out, e17);
    chk("R5 cascade moves with latch closed", 64'(grp_b_out), 64'(pf(2)));
    hold_val = e17;

    // reverse load
    dir_fwd = 0; grp_a_in = 4'hF; show = 0; pol = 0;
    for (int i = 0; i < 16; i++) begin grp_b_in = pr(i); tick(); end
    show = 1; pol = 1; #1;
    chk("R6 hold across R3 load", chan_out, hold_val);
    chk("R4 rev cascade", 64'(grp_a_out), 64'(pr(0)));
    chk("R4 rev idle group", 64'(grp_b_out), '0);
    for (int i = 0; i < 16; i++) e16[4*i +: 4] = rev4(pr(i));
    e17 = {rev4(pr(16)), e16[CH-1:4]};
    latch_en = 1; #1;
    chk("R3 R1 reverse map", chan_out, e16);
    grp_b_in = pr(16); tick();
    latch_en = 0; #1;
    chk("R6 reverse capture", chan_out, e17);
    grp_b_in = pr(17); tick();
    chk("R5 rev cascade advance", 64'(grp_a_out), 64'(pr(2)));

    // R7 output code table
    foreach (VEC[n]) begin
      logic [CH-1:0] ex;
      show = VEC[n][3]; pol = VEC[n][2]; #1;
      case (VEC[n][1:0])
        2'd0: ex = '1;
        2'd1: ex = '0;
        2'd2: ex = ~e17;
        default: ex = e17;
      endcase
      chk("R7 output code", chan_out, ex);
      @(negedge clk);
    end

    show = 1; pol = 1; rst_n = 0; #1;
    chk("R8 reset clears latch", chan_out, '0);
    chk("R8 reset clears cascade", 64'(grp_a_out), '0);
    tick(); rst_n = 1;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule